// File: doc/BRIEF.md
# Next Program Counter Unit

This block owns the fetch address of a 32-bit load/store processor whose instructions are all one 32-bit word wide. Each clock it chooses the next fetch address from three candidates: the address of the following word, a target relative to that following word for a conditional branch, or a pseudo-direct target for an unconditional jump. It then loads that address into its program counter register. The incremented address is also driven out, so the datapath can use it without adding 4 again.

The instruction decoder supplies a two-bit flow request. The datapath supplies the branch comparison result. The low 26 bits of the current instruction supply the offset or the jump index. A stall freezes the counter. A synchronous reset returns it to address zero. A branch that is not taken costs nothing extra, because the sequential address is always on hand. All target arithmetic is modulo 2^32.

Top module: `fetch_pc_unit`

## Requirements
- R1: While `rst` is high at a rising clock edge, `pc` becomes 0x0000_0000 on that edge, whatever `stall` and the other inputs are.
- R2: `pc_plus4` always equals `pc + 4` modulo 2^32. With `flow_req` = 2'b00 (sequential) and no stall, `pc` advances to `pc + 4` on the next edge. `cond_true` has no effect in this case.
- R3: With `flow_req` = 2'b01 (conditional branch), `cond_true` = 1 and no stall, the next `pc` is `pc + 4 + (sign-extended insn_field[15:0]) * 4`.
- R4: With `flow_req` = 2'b01 and `cond_true` = 0, the next `pc` is `pc + 4`. The offset bits have no effect.
- R5: With `flow_req[1]` = 1 (jump) and no stall, the next `pc` is `{pc_plus4[31:28], insn_field[25:0], 2'b00}`.
- R6: With `flow_req` = 2'b11 and `cond_true` = 1, the jump target of R5 is taken, not the branch target.
- R7: While `stall` is high and `rst` is low, `pc` keeps its value across the edge, even when a branch or a jump is requested.
- R8: `pc[1:0]` is always 2'b00 after reset.
- R9: Branch offsets cover the full signed 16-bit range. 0xFFFF goes back to the branch itself. 0x8000 moves back 2^17 bytes. 0x7FFF moves forward 2^17 - 4 bytes from `pc + 4`.
- R10: The upper 4 bits of a jump target come from `pc + 4`, not from `pc`. A jump held at 0x0FFF_FFFC lands in the region that starts at 0x1000_0000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| stall | input | 1 | Hold the program counter this cycle |
| flow_req | input | 2 | Bit 0 = conditional branch, bit 1 = jump, 00 = sequential |
| cond_true | input | 1 | Branch comparison result from the datapath |
| insn_field | input | 26 | Low 26 bits of the current instruction: jump index, with the branch offset in bits 15:0 |
| pc | output | 32 | Current program counter |
| pc_plus4 | output | 32 | Current program counter plus 4 |

## Verification
The stimulus table runs one continuous program path through each flow kind. It uses small positive offsets, offsets of -1 and -2, and both extreme 16-bit offsets, so the tests can tell a correct sign extension and word scaling apart from a zero-extended or unscaled offset. A branch that is not taken carries a non-zero offset, and a sequential step has `cond_true` high. Together these show whether the select logic looks at the wrong input. A jump with both request bits set proves that the jump has priority over the branch. A jump from 0x0FFF_FFFC tells a region taken from `pc + 4` apart from one taken from `pc`. Stalled redirects, and a reset asserted together with a stall, check the two overriding conditions.

// File: rtl/fetch_pc_pkg.sv
package fetch_pc_pkg;

    localparam int unsigned XLEN       = 32;
    localparam int unsigned INSN_BYTES = 4;
    localparam int unsigned ALIGN_BITS = $clog2(INSN_BYTES);
    localparam int unsigned BR_IMM_W   = 16;
    localparam int unsigned JMP_IDX_W  = 26;
    localparam int unsigned REGION_W   = XLEN - JMP_IDX_W - ALIGN_BITS;
    localparam logic [XLEN-1:0] RESET_PC = '0;

    // Decoded flow request: one bit per redirect kind
    typedef struct packed {
        logic jump;
        logic branch;
    } flow_req_t;

    // Source chosen for the next program counter value
    typedef enum logic [1:0] {
        NPC_HOLD   = 2'd0,
        NPC_SEQ    = 2'd1,
        NPC_BRANCH = 2'd2,
        NPC_JUMP   = 2'd3
    } npc_src_e;

    // Priority order: stall, jump, taken branch, sequential
    function automatic npc_src_e pick_source(input logic      hold,
                                             input flow_req_t req,
                                             input logic      taken);
        npc_src_e src;
        if (hold)
            src = NPC_HOLD;
        else if (req.jump)
            src = NPC_JUMP;
        else if (req.branch && taken)
            src = NPC_BRANCH;
        else
            src = NPC_SEQ;
        return src;
    endfunction

endpackage

// File: rtl/pc_step_adder.sv
module pc_step_adder #(
    parameter int unsigned WIDTH = 32,
    parameter int unsigned STEP  = 4
) (
    input  logic [WIDTH-1:0] base,
    output logic [WIDTH-1:0] sum
);
    localparam logic [WIDTH-1:0] STEP_V = WIDTH'(STEP);

    always_comb sum = base + STEP_V;
endmodule

// File: rtl/branch_target_unit.sv
module branch_target_unit #(
    parameter int unsigned WIDTH      = 32,
    parameter int unsigned IMM_W      = 16,
    parameter int unsigned ALIGN_BITS = 2
) (
    input  logic [WIDTH-1:0] seq_addr,
    input  logic [IMM_W-1:0] offset,
    output logic [WIDTH-1:0] target
);
    localparam int unsigned EXT_W = WIDTH - IMM_W - ALIGN_BITS;

    logic [WIDTH-1:0] scaled;

    // Sign-extend the word count and turn it into a byte displacement
    always_comb scaled = {{EXT_W{offset[IMM_W-1]}}, offset, {ALIGN_BITS{1'b0}}};
    always_comb target = seq_addr + scaled;
endmodule

// File: rtl/jump_target_unit.sv
module jump_target_unit #(
    parameter int unsigned IDX_W      = 26,
    parameter int unsigned REGION_W   = 4,
    parameter int unsigned ALIGN_BITS = 2
) (
    input  logic [REGION_W-1:0]                  region,
    input  logic [IDX_W-1:0]                     index,
    output logic [REGION_W+IDX_W+ALIGN_BITS-1:0] target
);
    // Region bits on top, word index in the middle, zero byte offset below
    always_comb target = {region, index, {ALIGN_BITS{1'b0}}};
endmodule

// File: rtl/next_pc_select.sv
module next_pc_select
    import fetch_pc_pkg::*;
#(
    parameter int unsigned WIDTH = 32
) (
    input  logic             stall,
    input  flow_req_t        req,
    input  logic             cond_true,
    input  logic [WIDTH-1:0] cur_pc,
    input  logic [WIDTH-1:0] seq_addr,
    input  logic [WIDTH-1:0] br_addr,
    input  logic [WIDTH-1:0] jmp_addr,
    output logic [WIDTH-1:0] next_pc
);
    npc_src_e src;

    always_comb src = pick_source(stall, req, cond_true);

    always_comb begin
        unique case (src)
            NPC_HOLD:   next_pc = cur_pc;
            NPC_JUMP:   next_pc = jmp_addr;
            NPC_BRANCH: next_pc = br_addr;
            default:    next_pc = seq_addr;
        endcase
    end
endmodule

// File: rtl/fetch_pc_unit.sv
module fetch_pc_unit
    import fetch_pc_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 stall,
    input  logic [1:0]           flow_req,
    input  logic                 cond_true,
    input  logic [JMP_IDX_W-1:0] insn_field,
    output logic [XLEN-1:0]      pc,
    output logic [XLEN-1:0]      pc_plus4
);
    logic [XLEN-1:0] pc_q;
    logic [XLEN-1:0] seq_addr;
    logic [XLEN-1:0] br_addr;
    logic [XLEN-1:0] jmp_addr;
    logic [XLEN-1:0] next_pc;
    flow_req_t       req;

    always_comb req = flow_req_t'(flow_req);

    pc_step_adder #(
        .WIDTH (XLEN),
        .STEP  (INSN_BYTES)
    ) u_step (
        .base (pc_q),
        .sum  (seq_addr)
    );

    branch_target_unit #(
        .WIDTH      (XLEN),
        .IMM_W      (BR_IMM_W),
        .ALIGN_BITS (ALIGN_BITS)
    ) u_br (
        .seq_addr (seq_addr),
        .offset   (insn_field[BR_IMM_W-1:0]),
        .target   (br_addr)
    );

    jump_target_unit #(
        .IDX_W      (JMP_IDX_W),
        .REGION_W   (REGION_W),
        .ALIGN_BITS (ALIGN_BITS)
    ) u_jmp (
        .region (seq_addr[XLEN-1 -: REGION_W]),
        .index  (insn_field),
        .target (jmp_addr)
    );

    next_pc_select #(
        .WIDTH (XLEN)
    ) u_sel (
        .stall     (stall),
        .req       (req),
        .cond_true (cond_true),
        .cur_pc    (pc_q),
        .seq_addr  (seq_addr),
        .br_addr   (br_addr),
        .jmp_addr  (jmp_addr),
        .next_pc   (next_pc)
    );

    always_ff @(posedge clk) begin
        if (rst)
            pc_q <= RESET_PC;
        else
            pc_q <= next_pc;
    end

    always_comb pc       = pc_q;
    always_comb pc_plus4 = seq_addr;
endmodule

// File: rtl/fetch_pc_unit_chk.sv
module fetch_pc_unit_chk
    import fetch_pc_pkg::*;
(
    input logic                 clk,
    input logic                 rst,
    input logic                 stall,
    input logic [1:0]           flow_req,
    input logic                 cond_true,
    input logic [JMP_IDX_W-1:0] insn_field,
    input logic [XLEN-1:0]      pc,
    input logic [XLEN-1:0]      pc_plus4
);
    localparam int unsigned EXT_W = XLEN - BR_IMM_W - ALIGN_BITS;

    logic [XLEN-1:0]     boff;
    logic [REGION_W-1:0] p4_region;

    always_comb boff      = {{EXT_W{insn_field[BR_IMM_W-1]}}, insn_field[BR_IMM_W-1:0], {ALIGN_BITS{1'b0}}};
    always_comb p4_region = pc_plus4[XLEN-1 -: REGION_W];

    AST_RESET_ZERO: assert property (@(posedge clk)
        rst |=> (pc == RESET_PC)); // R1

    AST_SEQ_STEP: assert property (@(posedge clk) disable iff (rst)
        (!stall && flow_req == 2'b00) |=> (pc == $past(pc) + 32'd4)); // R2

    AST_BRANCH_TAKEN: assert property (@(posedge clk) disable iff (rst)
        (!stall && flow_req == 2'b01 && cond_true) |=> (pc == $past(pc_plus4) + $past(boff))); // R3

    AST_BRANCH_FALLTHRU: assert property (@(posedge clk) disable iff (rst)
        (!stall && flow_req == 2'b01 && !cond_true) |=> (pc == $past(pc) + 32'd4)); // R4

    AST_JUMP_TARGET: assert property (@(posedge clk) disable iff (rst)
        (!stall && flow_req[1]) |=> (pc == {$past(p4_region), $past(insn_field), 2'b00})); // R5

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
        stall |=> $stable(pc)); // R7

    AST_WORD_ALIGNED: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (pc[ALIGN_BITS-1:0] == '0)); // R8
endmodule

bind fetch_pc_unit fetch_pc_unit_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .stall      (stall),
    .flow_req   (flow_req),
    .cond_true  (cond_true),
    .insn_field (insn_field),
    .pc         (pc),
    .pc_plus4   (pc_plus4)
);

// File: tb/fetch_pc_unit_tb.sv
module fetch_pc_unit_tb;

    typedef struct packed {
        logic        stall;
        logic [1:0]  flow;
        logic        cond;
        logic [25:0] field;
        logic [31:0] exp_pc;
    } vec_t;

    localparam int NVEC = 15;

    // Expected pc after each vector, worked out from R2..R10 starting at 0
    localparam vec_t VECS [NVEC] = '{
        '{1'b0, 2'b00, 1'b0, 26'h0000000, 32'h0000_0004},  // R2 sequential
        '{1'b0, 2'b00, 1'b1, 26'h0000010, 32'h0000_0008},  // R2 cond ignored
        '{1'b0, 2'b01, 1'b1, 26'h0000010, 32'h0000_004C},  // R3 forward +16 words
        '{1'b0, 2'b01, 1'b0, 26'h0000100, 32'h0000_0050},  // R4 not taken
        '{1'b0, 2'b01, 1'b1, 26'h000FFFF, 32'h0000_0050},  // R9 offset -1
        '{1'b0, 2'b01, 1'b1, 26'h000FFFE, 32'h0000_004C},  // R3 offset -2
        '{1'b0, 2'b10, 1'b0, 26'h0000400, 32'h0000_1000},  // R5 jump
        '{1'b1, 2'b10, 1'b0, 26'h3FFFFFF, 32'h0000_1000},  // R7 stalled jump
        '{1'b1, 2'b01, 1'b1, 26'h0000010, 32'h0000_1000},  // R7 stalled branch
        '{1'b0, 2'b11, 1'b1, 26'h0000010, 32'h0000_0040},  // R6 jump beats branch
        '{1'b0, 2'b10, 1'b0, 26'h3FFFFFF, 32'h0FFF_FFFC},  // R5 top of region 0
        '{1'b0, 2'b10, 1'b0, 26'h0000001, 32'h1000_0004},  // R10 region from pc+4
        '{1'b0, 2'b01, 1'b1, 26'h0007FFF, 32'h1002_0004},  // R9 max positive
        '{1'b0, 2'b01, 1'b1, 26'h0008000, 32'h1000_0008},  // R9 most negative
        '{1'b0, 2'b00, 1'b0, 26'h0000000, 32'h1000_000C}   // R2 sequential
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        stall = 1'b0;
    logic [1:0]  flow_req = 2'b00;
    logic        cond_true = 1'b0;
    logic [25:0] insn_field = '0;
    logic [31:0] pc;
    logic [31:0] pc_plus4;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;

    always #2 clk = ~clk;

    fetch_pc_unit u_dut (
        .clk        (clk),
        .rst        (rst),
        .stall      (stall),
        .flow_req   (flow_req),
        .cond_true  (cond_true),
        .insn_field (insn_field),
        .pc         (pc),
        .pc_plus4   (pc_plus4)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 5000) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected fewer than 5000", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) step();
        check("R1 reset pc", pc, 32'h0000_0000);
        check("R2 reset pc_plus4", pc_plus4, 32'h0000_0004);
        rst = 1'b0;

        for (int i = 0; i < NVEC; i++) begin
            stall      = VECS[i].stall;
            flow_req   = VECS[i].flow;
            cond_true  = VECS[i].cond;
            insn_field = VECS[i].field;
            step();
            check($sformatf("vector %0d pc (R2..R10)", i), pc, VECS[i].exp_pc);
            check($sformatf("vector %0d R2 pc_plus4", i), pc_plus4, VECS[i].exp_pc + 32'd4);
            check($sformatf("vector %0d R8 alignment", i), {30'd0, pc[1:0]}, 32'd0);
        end

        // R1: reset wins over a stall and a pending jump
        rst        = 1'b1;
        stall      = 1'b1;
        flow_req   = 2'b10;
        insn_field = 26'h0001234;
        step();
        check("R1 reset under stall", pc, 32'h0000_0000);

        // R7: stall alone holds the reset value
        rst = 1'b0;
        step();
        check("R7 hold after reset", pc, 32'h0000_0000);

        // R2: sequential resumes after the stall clears
        stall    = 1'b0;
        flow_req = 2'b00;
        step();
        check("R2 resume after stall", pc, 32'h0000_0004);

        // R4: not-taken branch with the most negative offset
        flow_req   = 2'b01;
        cond_true  = 1'b0;
        insn_field = 26'h0008000;
        step();
        check("R4 not taken, negative offset", pc, 32'h0000_0008);

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule